// File: doc/BRIEF.md
# Manchester Event Word Receiver

This block recovers fixed-width event words from a single-wire serial stream. The stream is Manchester coded and stays low between bursts. A gap may last any length of time, and no idle pattern is sent during it. A rising edge on the line marks the start of a burst. The receiver then decodes two leading alignment bits and the event bits that follow, counting on an oversampling local clock. Each bit cell must carry a mid-cell transition, and that transition re-centres the sampling phase. Once a word is complete it is presented on a valid/ready parallel port.

The serial side has a four-phase handshake. The transmitter raises `ser_req` for each event. The receiver raises `ser_ack` only after the parallel consumer has taken the word. The receiver drops `ser_ack` again once it sees `ser_req` low. Three faults raise a single-cycle `err` pulse, and in each case the burst is discarded:
- a malformed preamble;
- a bit cell that has no mid-cell transition;
- a word that completes while the previous one is still waiting.

After a burst ends or is aborted, the receiver goes back to waiting for the next rising edge.

Top module: `lnk_event_rx`

## Requirements
- R1: After reset `out_valid`, `err` and `ser_ack` are low. The idle line is low, and a burst is recognised only on a low-to-high change of `ser_din`.
- R2: A bit of value 1 is sent high for OSR samples, then low for OSR samples. A bit of value 0 is sent low, then high. Every burst starts with the alignment bits 1 then 0, followed by WORD_W data bits. With MSB_FIRST=1 the first data bit lands in `out_data[WORD_W-1]`.
- R3: Number the clock edge that first samples the high level of a burst as edge 0. With the default parameters, `out_valid` rises on edge 8*(2+WORD_W)+1, which is edge 273.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `out_valid` falls after the edge on which `out_ready` is high, unless a new word loads on that same edge.
- R5: `ser_ack` rises on the edge that hands a word to the consumer. It falls on the second edge after the edge that first samples `ser_req` low.
- R6: If the second alignment bit is 1, `err` pulses on edge 17 of that burst, no word is produced, and the receiver waits for the next rising edge.
- R7: Take a cell at position n, counting the alignment bits from 0. If its level does not change by mid-cell, `err` pulses on edge 8n+8, and the partial word is dropped.
- R8: If the first half of a cell is longer by one sample, the transition re-centres the sampling phase. The word is still decoded correctly, and every later event moves one cycle later.
- R9: A new burst is decoded correctly after any low gap of at least one sample, and after an aborted burst.
- R10: Suppose a word completes while an earlier word is pending and `out_ready` is low. Then `err` pulses, and the pending word stays on `out_data`.
- R11: `err` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 2*OSR samples per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Manchester-coded serial data, low when idle |
| ser_req | input | 1 | Transmitter request, asynchronous |
| ser_ack | output | 1 | Acknowledge returned to the transmitter |
| out_valid | output | 1 | Parallel word available |
| out_ready | input | 1 | Consumer takes the word on an edge where this is high |
| out_data | output | WORD_W | Recovered event word |
| err | output | 1 | One-cycle fault pulse |

## Verification
Suppose the cell phase counter or the bit index is wrong by even one step. Then `out_valid` or `err` moves to a different clock cycle within the same burst, and `out_data` shows a shifted or corrupted word. The reference model predicts the exact edge of each event from the timing of the stimulus, and it compares every port on every cycle. Such faults therefore show up on the first cycle at which the ports diverge. A handshake state fault shows on `ser_ack` within two or three cycles of an accept or a request drop.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
   typedef enum logic {
      CELL_IDLE = 1'b0,
      CELL_RUN  = 1'b1
   } cell_state_t;
endpackage

// File: rtl/lnk_sync.sv
module lnk_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lnk_cell.sv
module lnk_cell
   import lnk_pkg::*;
#(
   parameter int OSR = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic halt,
   output logic bit_stb,
   output logic bit_val,
   output logic cell_err
);
   localparam int CELL   = 2 * OSR;
   localparam int CW     = $clog2(CELL);
   localparam int SAMP   = OSR / 2;
   localparam int WIN_LO = SAMP + 1;
   localparam int WIN_HI = OSR + SAMP - 1;
   localparam int CHK    = OSR + SAMP;

   cell_state_t   state;
   logic [CW-1:0] cnt;
   logic          h1;
   logic          seen;
   logic          prev;
   logic          run;
   logic          in_win;

   assign run      = (state == CELL_RUN);
   assign in_win   = (cnt >= CW'(WIN_LO)) && (cnt <= CW'(WIN_HI));
   assign cell_err = run && (cnt == CW'(CHK)) && (line == h1);
   assign bit_stb  = run && (cnt == CW'(CELL - 1));
   assign bit_val  = h1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CELL_IDLE;
         cnt   <= '0;
         h1    <= 1'b0;
         seen  <= 1'b0;
         prev  <= 1'b1;
      end else begin
         prev <= line;
         case (state)
            CELL_IDLE: begin
               if (line && !prev) begin
                  state <= CELL_RUN;
                  cnt   <= CW'(1);
                  seen  <= 1'b0;
               end
            end
            CELL_RUN: begin
               if (cell_err) begin
                  state <= CELL_IDLE;
               end else if (bit_stb) begin
                  cnt  <= '0;
                  seen <= 1'b0;
                  if (halt) state <= CELL_IDLE;
               end else if (in_win && !seen && (line != h1)) begin
                  seen <= 1'b1;
                  cnt  <= CW'(OSR + 1);
               end else begin
                  cnt <= cnt + 1'b1;
                  if (cnt == CW'(SAMP)) h1 <= line;
               end
            end
            default: state <= CELL_IDLE;
         endcase
      end
   end

   // R7: a cell may only complete after its mid-cell transition was found
   assert_cell_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> seen);

   // R8: a re-centred transition always leaves the phase inside the second half
   assert_recentre_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seen) |-> (cnt == CW'(OSR + 1)));
endmodule

// File: rtl/lnk_frame.sv
module lnk_frame #(
   parameter int                 WORD_W    = 32,
   parameter int                 PRE_W     = 2,
   parameter logic [PRE_W-1:0]   PRE_PAT   = 2'b10,
   parameter bit                 MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              cell_err,
   input  logic              out_ready,
   input  logic              req_s,
   output logic              halt,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              err,
   output logic              ser_ack
);
   localparam int TOT = PRE_W + WORD_W;
   localparam int IW  = $clog2(TOT);
   localparam int PW  = PRE_W - 1;

   logic [IW-1:0]     idx;
   logic [PW-1:0]     pre_sh;
   logic [WORD_W-1:0] sh;
   logic [WORD_W-1:0] nxt;
   logic              pre_ok, at_pre_end, at_end;
   logic              pre_bad, done, accept, load, overrun;

   generate
      if (MSB_FIRST) begin : g_msb
         assign nxt = {sh[WORD_W-2:0], bit_val};
      end else begin : g_lsb
         assign nxt = {bit_val, sh[WORD_W-1:1]};
      end
   endgenerate

   assign pre_ok     = ({pre_sh, bit_val} == PRE_PAT);
   assign at_pre_end = (idx == IW'(PRE_W - 1));
   assign at_end     = (idx == IW'(TOT - 1));
   assign halt       = at_end || (at_pre_end && !pre_ok);
   assign pre_bad    = bit_stb && at_pre_end && !pre_ok;
   assign done       = bit_stb && at_end;
   assign accept     = out_valid && out_ready;
   assign load       = done && (!out_valid || out_ready);
   assign overrun    = done && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx       <= '0;
         pre_sh    <= '0;
         sh        <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         err       <= 1'b0;
         ser_ack   <= 1'b0;
      end else begin
         err <= cell_err || pre_bad || overrun;
         if (cell_err || (bit_stb && halt)) idx <= '0;
         else if (bit_stb)                  idx <= idx + 1'b1;
         if (bit_stb) begin
            if (idx < IW'(PRE_W - 1)) pre_sh <= PW'({pre_sh, bit_val});
            if (idx >= IW'(PRE_W))    sh     <= nxt;
         end
         if (load) begin
            out_valid <= 1'b1;
            out_data  <= nxt;
         end else if (accept) begin
            out_valid <= 1'b0;
         end
         if (accept)                 ser_ack <= 1'b1;
         else if (ser_ack && !req_s) ser_ack <= 1'b0;
      end
   end

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   assert_ack_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_ack) |-> $past(out_valid && out_ready));

   assert_err_noword_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !$rose(out_valid));

   assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
endmodule

// File: rtl/lnk_event_rx.sv
module lnk_event_rx #(
   parameter int               WORD_W      = 32,
   parameter int               OSR         = 4,
   parameter int               PRE_W       = 2,
   parameter logic [PRE_W-1:0] PRE_PAT     = 2'b10,
   parameter int               SYNC_STAGES = 2,
   parameter bit               MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_din,
   input  logic              ser_req,
   output logic              ser_ack,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              err
);
   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (PRE_W < 2 || !PRE_PAT[PRE_W-1]) begin : g_bad_pre
         $error("preamble needs two or more bits and must open with a 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic line, req_s, halt, bit_stb, bit_val, cell_err;

   lnk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din_sync (
      .clk(clk), .rst_n(rst_n), .d(ser_din), .q(line));

   lnk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(ser_req), .q(req_s));

   lnk_cell #(.OSR(OSR)) u_cell (
      .clk(clk), .rst_n(rst_n), .line(line), .halt(halt),
      .bit_stb(bit_stb), .bit_val(bit_val), .cell_err(cell_err));

   lnk_frame #(.WORD_W(WORD_W), .PRE_W(PRE_W), .PRE_PAT(PRE_PAT),
               .MSB_FIRST(MSB_FIRST)) u_frame (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
      .cell_err(cell_err), .out_ready(out_ready), .req_s(req_s),
      .halt(halt), .out_valid(out_valid), .out_data(out_data),
      .err(err), .ser_ack(ser_ack));
endmodule

// File: tb/lnk_event_rx_test.sv
`timescale 1ns/1ps
module lnk_event_rx_test;
   localparam int W = 32;
   localparam int OSR = 4;

   logic clk = 1'b0, rst_n = 1'b0, ser_din = 1'b0, ser_req = 1'b0, out_ready = 1'b0;
   wire ser_ack, out_valid, err;
   wire [W-1:0] out_data;

   lnk_event_rx uut (
      .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_req(ser_req),
      .ser_ack(ser_ack), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .err(err));

   always #2 clk = ~clk;

   int cyc = 0, checks = 0, errors = 0;
   int ev_cyc[$];
   int ev_kind[$];
   logic [W-1:0] ev_data[$];
   logic m_valid = 0, m_err = 0, m_ack = 0, r1 = 0, r2 = 0, acc = 0, ld = 0;
   logic [W-1:0] m_data = '0;
   logic [W-1:0] got[$];
   int got_cyc[$];
   int err_cnt = 0, err_long = 0;
   logic pv = 0, pe = 0;

   task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // reference model: event schedule applied at the predicted edges
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         m_valid = 0; m_err = 0; m_ack = 0; r1 = 0; r2 = 0; m_data = '0;
      end else begin
         acc = m_valid && out_ready;
         ld = 0;
         m_err = 0;
         while (ev_cyc.size() != 0 && ev_cyc[0] == cyc) begin
            if (ev_kind[0] == 1) begin
               if (!m_valid || out_ready) begin m_data = ev_data[0]; ld = 1; end
               else m_err = 1;
            end else begin
               m_err = 1;
            end
            void'(ev_cyc.pop_front());
            void'(ev_kind.pop_front());
            void'(ev_data.pop_front());
         end
         if (ld) m_valid = 1;
         else if (acc) m_valid = 0;
         if (acc) m_ack = 1;
         else if (m_ack && !r2) m_ack = 0;
         r2 = r1;
         r1 = ser_req;
      end
   end

   // per-cycle comparison and monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         cmp("R3 out_valid", W'(out_valid), W'(m_valid));
         cmp("R11 err", W'(err), W'(m_err));
         cmp("R5 ser_ack", W'(ser_ack), W'(m_ack));
         if (m_valid) cmp("R2 out_data", out_data, m_data);
         if (out_valid && !pv) begin got.push_back(out_data); got_cyc.push_back(cyc); end
         if (err && !pe) err_cnt++;
         if (err && pe) err_long++;
         pv = out_valid;
         pe = err;
      end
   end

   task automatic drive_half(input logic v, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ser_din = v;
      end
   endtask

   // pbad: second alignment bit sent as 1; bad: data bit without transition;
   // str: data bit whose first half is one sample longer
   task automatic send(input logic [W-1:0] w, input int bad, input int str,
                       input int pbad, input int gap, output int s);
      logic b;
      int sh;
      ser_req = 1'b1;
      @(negedge clk);
      ser_din = 1'b1;
      s = cyc + 1;
      sh = (str >= 0) ? 1 : 0;
      if (pbad != 0) begin
         ev_cyc.push_back(s + 17); ev_kind.push_back(0); ev_data.push_back('0);
      end else if (bad >= 0) begin
         ev_cyc.push_back(s + 8 * (bad + 2) + 8); ev_kind.push_back(0); ev_data.push_back('0);
      end else begin
         ev_cyc.push_back(s + 8 * (W + 2) + 1 + sh); ev_kind.push_back(1); ev_data.push_back(w);
      end
      drive_half(1'b1, OSR - 1);
      drive_half(1'b0, OSR);
      b = (pbad != 0);
      drive_half(b, OSR);
      drive_half(!b, OSR);
      if (pbad == 0) begin
         for (int i = 0; i < W; i++) begin
            b = w[W-1-i];
            if (i == bad) begin
               drive_half(b, 2 * OSR);
               break;
            end
            drive_half(b, OSR + ((i == str) ? 1 : 0));
            drive_half(!b, OSR);
         end
      end
      drive_half(1'b0, gap);
   endtask

   task automatic accept_word();
      @(negedge clk); out_ready = 1'b1;
      @(negedge clk); out_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int s, n0, e0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1 reset out_valid", W'(out_valid), '0);
      cmp("R1 reset err", W'(err), '0);
      cmp("R1 reset ser_ack", W'(ser_ack), '0);
      repeat (6) @(negedge clk);

      // held word, then handshake
      send(32'hA5C3_0F96, -1, -1, 0, 10, s);
      repeat (5) @(negedge clk);
      cmp("R2 first word", got[got.size()-1], 32'hA5C3_0F96);
      cmp("R3 valid edge", W'(got_cyc[got_cyc.size()-1]), W'(s + 273));
      repeat (20) @(negedge clk);
      cmp("R4 held valid", W'(out_valid), W'(1));
      cmp("R4 held data", out_data, 32'hA5C3_0F96);
      accept_word();
      cmp("R4 valid after accept", W'(out_valid), '0);
      cmp("R5 ack after accept", W'(ser_ack), W'(1));
      ser_req = 1'b0;
      repeat (3) @(negedge clk);
      cmp("R5 ack after req drop", W'(ser_ack), '0);

      // back-to-back patterns with one-sample gaps
      out_ready = 1'b1;
      n0 = got.size();
      send(32'h0000_0000, -1, -1, 0, 1, s);
      send(32'hFFFF_FFFF, -1, -1, 0, 1, s);
      send(32'h5555_AAAA, -1, -1, 0, 10, s);
      cmp("R9 word count", W'(got.size() - n0), W'(3));
      cmp("R9 zeros", got[n0], 32'h0);
      cmp("R9 ones", got[n0+1], 32'hFFFF_FFFF);
      cmp("R9 mixed", got[n0+2], 32'h5555_AAAA);

      // stretched half-cell
      send(32'h1234_5678, -1, 5, 0, 10, s);
      cmp("R8 stretched word", got[got.size()-1], 32'h1234_5678);
      cmp("R8 shifted edge", W'(got_cyc[got_cyc.size()-1]), W'(s + 274));

      // bad preamble
      e0 = err_cnt; n0 = got.size();
      send(32'h0, -1, -1, 1, 12, s);
      cmp("R6 err count", W'(err_cnt - e0), W'(1));
      cmp("R6 no word", W'(got.size() - n0), '0);

      // missing transition, then recovery
      e0 = err_cnt; n0 = got.size();
      send(32'hDEAD_BEEF, 10, -1, 0, 12, s);
      cmp("R7 err count", W'(err_cnt - e0), W'(1));
      cmp("R7 no word", W'(got.size() - n0), '0);
      send(32'h0F0F_F0F0, -1, -1, 0, 10, s);
      cmp("R9 recovery word", got[got.size()-1], 32'h0F0F_F0F0);
      ser_req = 1'b0;
      repeat (5) @(negedge clk);

      // overrun
      out_ready = 1'b0;
      e0 = err_cnt;
      send(32'hCAFE_0001, -1, -1, 0, 3, s);
      send(32'h0000_BEEF, -1, -1, 0, 10, s);
      cmp("R10 err count", W'(err_cnt - e0), W'(1));
      cmp("R10 still valid", W'(out_valid), W'(1));
      cmp("R10 data kept", out_data, 32'hCAFE_0001);
      accept_word();
      cmp("R4 valid cleared", W'(out_valid), '0);
      cmp("R5 ack raised", W'(ser_ack), W'(1));
      ser_req = 1'b0;
      repeat (4) @(negedge clk);
      cmp("R5 ack cleared", W'(ser_ack), '0);
      cmp("R11 no long err", W'(err_long), '0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule